// File: doc/BRIEF.md
# Overflow-Interrupt Timer Pair

This block holds two identical 32-bit up-counting timers behind one small register bus. Each timer starts counting from a value that software loads. When a counting tick finds the count at all-ones, the timer wraps: it reloads the loaded value, sets a sticky pending flag and keeps running. To get a timeout, software loads the all-ones value minus the wanted distance. A free-running timer started from zero gives a readable time base.

Each timer has a prescaler. The prescaler sets how many input clocks make one counting tick. Control is split in two. One control register takes one-shot halt and start strobes. A configuration register holds the enable and interrupt-enable bits. Each timer drives its own level interrupt, which is the pending flag gated by interrupt-enable. The two timers occupy consecutive 0x40-byte windows. Reads are combinational from the address, and writes take effect at the next rising clock edge.

Top module: `ovf_timer_pair`

## Requirements
- R1: After synchronous reset, every register of both timers reads 0 and both interrupt outputs are low.
- R2: Within a timer window, the offsets are: 0x00 pending flag (bit 0), 0x04 live count, 0x10 control, 0x20 configuration (bit 0 enable, bit 1 interrupt enable), 0x24 prescale divisor, 0x28 load value. Any other offset, and any address at or above 0x80, reads 0. Writes to the count offset are ignored.
- R3: Writing control with bit 0 set copies the load value into the count, stops counting and clears the prescaler. The count then stays put until a start.
- R4: Writing control with bit 1 set and bit 0 clear starts the timer. If both bits are set, the halt wins. Control reads back as bit 1 = running.
- R5: Counting only advances while the timer is started and configuration bit 0 is set. Clearing bit 0 freezes the count.
- R6: With divisor N, the count advances once every N+1 enabled clocks. Divisor 0 advances on every clock.
- R7: A tick that finds the count at 0xFFFFFFFF reloads the load value, sets the pending flag and leaves the timer running.
- R8: Writing 1 to bit 0 of the pending-flag offset clears the flag. Writing 0 has no effect. An overflow in the same cycle keeps the flag set.
- R9: A timer's interrupt output equals its pending flag ANDed with configuration bit 1.
- R10: Timer k lives at base 0x40*k, and activity in one timer never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 2 | Level interrupt per timer |

## Verification
The bench builds the block with its default parameters: two timers, a 32-bit count, a 16-bit divisor and an 8-bit address. Because the count is a full 32 bits, overflow is only reached within the bench run by loading values a few ticks below all-ones. The narrow address still leaves room for unmapped windows above the second timer. Small divisors let the bench compare the prescaled stepping against a behavioural reference on every cycle.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;

    localparam int BUS_W      = 32;
    localparam int OFF_W      = 6;
    localparam int UNIT_SHIFT = 6;

    localparam logic [OFF_W-1:0] OFF_FLAG  = 6'h00;
    localparam logic [OFF_W-1:0] OFF_COUNT = 6'h04;
    localparam logic [OFF_W-1:0] OFF_CTRL  = 6'h10;
    localparam logic [OFF_W-1:0] OFF_CFG   = 6'h20;
    localparam logic [OFF_W-1:0] OFF_DIV   = 6'h28 - 6'h04;
    localparam logic [OFF_W-1:0] OFF_LOAD  = 6'h28;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_FLAG,
        RS_COUNT,
        RS_CTRL,
        RS_CFG,
        RS_DIV,
        RS_LOAD
    } reg_sel_e;

    typedef struct packed {
        logic irq_en;
        logic run_en;
    } cfg_t;

    typedef struct packed {
        logic halt;
        logic start;
        logic flag_clr;
    } cmd_t;

    function automatic reg_sel_e decode_off(input logic [OFF_W-1:0] off);
        reg_sel_e s;
        case (off)
            OFF_FLAG:  s = RS_FLAG;
            OFF_COUNT: s = RS_COUNT;
            OFF_CTRL:  s = RS_CTRL;
            OFF_CFG:   s = RS_CFG;
            OFF_DIV:   s = RS_DIV;
            OFF_LOAD:  s = RS_LOAD;
            default:   s = RS_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ovf_prescaler.sv
module ovf_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    // A divisor lowered below the running count ends the period at once.
    assign tick = advance && (cnt_q >= divisor);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end

    assert_tick_restart_R6: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == '0));

    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (!advance && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/ovf_timer_unit.sv
module ovf_timer_unit
    import ovf_timer_pkg::*;
#(
    parameter int COUNT_W = 32,
    parameter int DIV_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] off,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rd_data,
    output logic             irq
);
    localparam logic [COUNT_W-1:0] COUNT_MAX = '1;

    reg_sel_e           sel;
    cmd_t               cmd;
    cfg_t               cfg_q;
    logic [DIV_W-1:0]   div_q;
    logic [COUNT_W-1:0] load_q;
    logic [COUNT_W-1:0] count_q;
    logic               running_q;
    logic               flag_q;
    logic               tick;
    logic               wrap;

    assign sel          = decode_off(off);
    assign cmd.halt     = wr_en && (sel == RS_CTRL) && wdata[0];
    assign cmd.start    = wr_en && (sel == RS_CTRL) && wdata[1] && !wdata[0];
    assign cmd.flag_clr = wr_en && (sel == RS_FLAG) && wdata[0];

    ovf_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .clear   (cmd.halt),
        .advance (running_q && cfg_q.run_en),
        .divisor (div_q),
        .tick    (tick)
    );

    assign wrap = tick && (count_q == COUNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            div_q  <= '0;
            load_q <= '0;
        end else if (wr_en) begin
            case (sel)
                RS_CFG:  cfg_q  <= cfg_t'(wdata[1:0]);
                RS_DIV:  div_q  <= wdata[DIV_W-1:0];
                RS_LOAD: load_q <= wdata[COUNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
        end else if (cmd.halt) begin
            running_q <= 1'b0;
        end else if (cmd.start) begin
            running_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (cmd.halt) begin
            count_q <= load_q;
        end else if (tick) begin
            count_q <= wrap ? load_q : count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (wrap) begin
            flag_q <= 1'b1;
        end else if (cmd.flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign irq = flag_q && cfg_q.irq_en;

    always_comb begin
        rd_data = '0;
        case (sel)
            RS_FLAG:  rd_data = BUS_W'(flag_q);
            RS_COUNT: rd_data = BUS_W'(count_q);
            RS_CTRL:  rd_data = BUS_W'({running_q, 1'b0});
            RS_CFG:   rd_data = BUS_W'(cfg_q);
            RS_DIV:   rd_data = BUS_W'(div_q);
            RS_LOAD:  rd_data = BUS_W'(load_q);
            default:  rd_data = '0;
        endcase
    end

    assert_halt_loads_R3: assert property (@(posedge clk) disable iff (rst)
        cmd.halt |=> (count_q == $past(load_q)) && !running_q);

    assert_step_one_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !wrap && !cmd.halt) |=> (count_q == $past(count_q) + 1'b1));

    assert_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cmd.halt) |=> $stable(count_q));

    assert_wrap_reload_R7: assert property (@(posedge clk) disable iff (rst)
        wrap |=> flag_q && (count_q == $past(load_q)));

    assert_clear_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd.flag_clr && !wrap) |=> !flag_q);

endmodule

// File: rtl/ovf_timer_pair.sv
module ovf_timer_pair
    import ovf_timer_pkg::*;
#(
    parameter int NUM_UNITS = 2,
    parameter int ADDR_W    = 8,
    parameter int COUNT_W   = 32,
    parameter int DIV_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    output logic [NUM_UNITS-1:0] irq
);
    localparam int SEL_W  = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
    localparam int HIGH_LO = UNIT_SHIFT + SEL_W;

    logic [SEL_W-1:0]     unit_idx;
    logic                 in_range;
    logic [NUM_UNITS-1:0] hit;
    logic [BUS_W-1:0]     unit_rd [NUM_UNITS];

    assign unit_idx = bus_addr[UNIT_SHIFT +: SEL_W];
    assign in_range = (bus_addr[ADDR_W-1:HIGH_LO] == '0);

    for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
        assign hit[k] = in_range && (unit_idx == SEL_W'(k));

        ovf_timer_unit #(.COUNT_W(COUNT_W), .DIV_W(DIV_W)) u_tmr (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (bus_we && hit[k]),
            .off     (bus_addr[OFF_W-1:0]),
            .wdata   (bus_wdata),
            .rd_data (unit_rd[k]),
            .irq     (irq[k])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_UNITS; k++) begin
            if (hit[k]) bus_rdata = bus_rdata | unit_rd[k];
        end
    end

    assert_one_window_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (irq == '0));

endmodule

// File: tb/ovf_timer_pair_test.sv
module ovf_timer_pair_test;
    logic        clk = 0;
    logic        rst = 1;
    logic [7:0]  bus_addr = 0;
    logic        bus_we = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    ovf_timer_pair uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // behavioural reference state
    logic [31:0] m_cnt [2];
    logic [31:0] m_load[2];
    logic [15:0] m_div [2];
    int          m_pre [2];
    bit          m_run [2];
    bit          m_en  [2];
    bit          m_ie  [2];
    bit          m_flag[2];

    always @(posedge clk) begin
        for (int u = 0; u < 2; u++) begin
            if (rst) begin
                m_cnt[u] = 0; m_load[u] = 0; m_div[u] = 0; m_pre[u] = 0;
                m_run[u] = 0; m_en[u] = 0; m_ie[u] = 0; m_flag[u] = 0;
            end else begin
                bit hitw, halt, start, tk;
                int o;
                hitw  = bus_we && (bus_addr[7] == 0) && (bus_addr[6] == u[0]);
                o     = int'(bus_addr[5:0]);
                halt  = hitw && o == 'h10 && bus_wdata[0];
                start = hitw && o == 'h10 && bus_wdata[1] && !bus_wdata[0];
                tk    = m_run[u] && m_en[u] && (m_pre[u] >= int'(m_div[u]));
                if (tk && m_cnt[u] == 32'hFFFF_FFFF) m_flag[u] = 1;
                else if (hitw && o == 0 && bus_wdata[0]) m_flag[u] = 0;
                if (halt) m_cnt[u] = m_load[u];
                else if (tk) m_cnt[u] = (m_cnt[u] == 32'hFFFF_FFFF) ? m_load[u] : m_cnt[u] + 1;
                if (halt) m_pre[u] = 0;
                else if (m_run[u] && m_en[u]) m_pre[u] = tk ? 0 : m_pre[u] + 1;
                if (halt) m_run[u] = 0;
                else if (start) m_run[u] = 1;
                if (hitw && o == 'h20) begin m_en[u] = bus_wdata[0]; m_ie[u] = bus_wdata[1]; end
                if (hitw && o == 'h24) m_div[u] = bus_wdata[15:0];
                if (hitw && o == 'h28) m_load[u] = bus_wdata;
            end
        end
    end

    function automatic logic [31:0] mread(input logic [7:0] a);
        int u;
        if (a[7]) return 0;
        u = int'(a[6]);
        case (a[5:0])
            6'h00: return {31'b0, m_flag[u]};
            6'h04: return m_cnt[u];
            6'h10: return {30'b0, m_run[u], 1'b0};
            6'h20: return {30'b0, m_ie[u], m_en[u]};
            6'h24: return {16'b0, m_div[u]};
            6'h28: return m_load[u];
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // interrupt outputs compared with the reference on every cycle (R9)
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R9 irq0", {31'b0, irq[0]}, {31'b0, m_flag[0] & m_ie[0]});
            check("R9 irq1", {31'b0, irq[1]}, {31'b0, m_flag[1] & m_ie[1]});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, mread(a));
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, e);
        check({tag, " model"}, bus_rdata, mread(a));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        foreach (uut.irq[i]) check("R1 irq", {31'b0, irq[i]}, 32'h0);
        for (int u = 0; u < 2; u++) begin
            rd_exp(8'(u * 64 + 'h00), 0, "R1 flag");
            rd_exp(8'(u * 64 + 'h04), 0, "R1 count");
            rd_exp(8'(u * 64 + 'h10), 0, "R1 ctrl");
            rd_exp(8'(u * 64 + 'h20), 0, "R1 cfg");
            rd_exp(8'(u * 64 + 'h24), 0, "R1 div");
            rd_exp(8'(u * 64 + 'h28), 0, "R1 load");
        end
        // R3 halt loads, stays put
        wr(8'h28, 32'hFFFF_FFF0);
        wr(8'h20, 32'h3);
        wr(8'h10, 32'h1);
        rd_exp(8'h04, 32'hFFFF_FFF0, "R3 loaded");
        idle(5);
        rd_exp(8'h04, 32'hFFFF_FFF0, "R3 held");
        // R4 start, count by one per clock (R6 divisor 0)
        wr(8'h10, 32'h2);
        rd_exp(8'h10, 32'h2, "R4 running");
        rd(8'h04, "R4 counting");
        rd(8'h04, "R6 div0 step");
        // R7 overflow, reload, flag, keeps running
        idle(20);
        rd_exp(8'h00, 32'h1, "R7 flag set");
        rd(8'h04, "R7 reloaded");
        rd_exp(8'h10, 32'h2, "R7 still running");
        // R8 clear
        wr(8'h10, 32'h1);
        wr(8'h00, 32'h0);
        rd_exp(8'h00, 32'h1, "R8 write0 no effect");
        wr(8'h00, 32'h1);
        rd_exp(8'h00, 32'h0, "R8 cleared");
        // R5 enable off freezes
        wr(8'h28, 32'h0000_1000);
        wr(8'h10, 32'h1);
        wr(8'h10, 32'h2);
        idle(3);
        wr(8'h20, 32'h2);
        rd(8'h04, "R5 frozen a");
        idle(4);
        rd(8'h04, "R5 frozen b");
        wr(8'h20, 32'h3);
        idle(2);
        rd(8'h04, "R5 resumed");
        // R6 divisor 3
        wr(8'h24, 32'h3);
        wr(8'h10, 32'h1);
        rd_exp(8'h04, 32'h0000_1000, "R6 reload");
        wr(8'h10, 32'h2);
        for (int i = 0; i < 10; i++) rd(8'h04, "R6 prescaled");
        idle(8);
        rd(8'h04, "R6 prescaled late");
        // R4 both bits: halt wins
        wr(8'h10, 32'h3);
        rd_exp(8'h10, 32'h0, "R4 halt wins");
        rd_exp(8'h04, 32'h0000_1000, "R4 halt wins count");
        // R10 second timer, irq masked (R9)
        wr(8'h68, 32'hFFFF_FFFD);
        wr(8'h60, 32'h1);
        wr(8'h50, 32'h1);
        wr(8'h50, 32'h2);
        idle(8);
        rd_exp(8'h40, 32'h1, "R10 unit1 flag");
        check("R9 masked irq1", {31'b0, irq[1]}, 32'h0);
        rd_exp(8'h00, 32'h0, "R10 unit0 flag untouched");
        rd_exp(8'h04, 32'h0000_1000, "R10 unit0 count untouched");
        wr(8'h60, 32'h3);
        idle(1);
        check("R9 unmasked irq1", {31'b0, irq[1]}, 32'h1);
        // R2 map details
        wr(8'h04, 32'h1234_5678);
        rd_exp(8'h04, 32'h0000_1000, "R2 count write ignored");
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_exp(8'h0C, 32'h0, "R2 hole");
        rd_exp(8'h2C, 32'h0, "R2 hole2");
        wr(8'h88, 32'hFFFF_FFFF);
        rd_exp(8'h88, 32'h0, "R2 beyond");
        rd_exp(8'h28, 32'h0000_1000, "R2 load kept");
        rd_exp(8'h24, 32'h3, "R2 div");
        idle(2);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule